// File: doc/BRIEF.md
# Supervisory Power-On Reset Generator

This block produces the reset for a processor from two fault conditions. The first is a supply-low flag that an external analog comparator has already digitized. The second is a push-button or logic-driven manual reset that is active low. Either condition forces reset on within a few clock cycles and keeps it on for as long as the condition lasts. Once both conditions have cleared, reset stays on for a further stretch interval before it is released. The interval is counted in pulses of a one-millisecond tick enable and defaults to 200.

A single stretch counter serves both inputs. It reloads to its full value in every cycle in which either condition is active, and it counts down on ticks only while both are quiet. This has three effects. A brownout in the middle of a pulse restarts the whole interval. A manual release always gives a full interval. Contact bounce on the button is absorbed without a separate debouncer. Both inputs pass through a two-flop synchronizer. The block drives the reset in both polarities: one output is active low and the other is active high.

Top module: `sysrst_supervisor`

## Requirements
- R1: While `rst_i` is high at a clock edge, the block returns to its asserted state: `rst_n_o` = 0, `rst_o` = 1. After `rst_i` falls with both inputs quiet, release follows R3 timing, that is, at the (STRETCH_MS+2)-th edge that samples a tick.
- R2: `vlow_i` = 1, sampled at one clock edge, makes `rst_n_o` low by the third edge after it, and not before that edge. `rst_n_o` then stays low for as long as `vlow_i` stays high.
- R3: After `vlow_i` falls, `rst_n_o` stays low until STRETCH_MS tick-enabled edges have passed, counted from the third edge after the fall. With a tick in every cycle, `rst_n_o` rises at the (STRETCH_MS+2)-th edge.
- R4: `mr_n_i` = 0, sampled at one clock edge, makes `rst_n_o` low by the third edge after it, and reset stays low for as long as `mr_n_i` stays low.
- R5: A rise of `mr_n_i` gives the same full stretch as R3.
- R6: A supply-low event during a stretch already in progress reloads the counter. The full STRETCH_MS ticks then run again after the event ends.
- R7: `rst_o` is always the exact complement of `rst_n_o`.
- R8: Repeated short lows on `mr_n_i`, each one clock long, keep reset low. Release comes a full stretch after the last rise.
- R9: Ticks that arrive while either condition is active do not shorten the stretch that follows.
- R10: Reset is released only at an edge that samples `ms_tick_i` = 1. With no ticks, reset never releases.
- R11: Once released, and with both inputs quiet, reset stays deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset; forces reset output on |
| ms_tick_i | input | 1 | One-cycle enable once per millisecond |
| vlow_i | input | 1 | Digitized supply-low flag, active high, asynchronous |
| mr_n_i | input | 1 | Manual reset request, active low, asynchronous |
| rst_n_o | output | 1 | Processor reset, active low |
| rst_o | output | 1 | Processor reset, active high |

## Verification
The assertions assume that each fault input stays at a level for at least one full clock period, so that the synchronizer captures it. They also assume that `ms_tick_i` is a clean synchronous enable. The bench drives every input on the falling clock edge and holds each level for a whole number of cycles. Its shortest pulses are single-cycle lows on `mr_n_i`, which is the minimum the assertions rely on. Its tick stream is either continuous or fully absent, so that the release edge can be predicted exactly.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;

    // Synchronized fault inputs, one bit each.
    typedef struct packed {
        logic supply_low;   // 1 = supply below threshold
        logic manual_n;     // 0 = manual reset requested
    } sup_in_t;

    // Value the synchronizer holds during reset: both faults present.
    localparam sup_in_t SUP_IN_FAULT = '{supply_low: 1'b1, manual_n: 1'b0};

    // Phase of the stretch machine.
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,    // a fault is present, counter pinned at full
        ST_COUNT = 2'd1,    // faults gone, draining on ticks
        ST_RUN   = 2'd2     // stretch expired, reset released
    } stretch_st_e;

    function automatic logic fault_present(sup_in_t s);
        return s.supply_low | ~s.manual_n;
    endfunction

    function automatic int unsigned cnt_bits(int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/sysrst_sync.sv
module sysrst_sync #(
    parameter int unsigned     WIDTH   = 2,
    parameter int unsigned     STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/sysrst_stretch.sv
module sysrst_stretch
    import sysrst_pkg::*;
#(
    parameter int unsigned STRETCH = 200
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    input  logic hold_i,
    output logic active_o
);

    localparam int unsigned    CW   = cnt_bits(STRETCH);
    localparam logic [CW-1:0]  LOAD = CW'(STRETCH);
    localparam logic [CW-1:0]  ONE  = CW'(1);

    logic [CW-1:0] cnt_q;
    stretch_st_e   st_q;
    stretch_st_e   st_next;
    logic          last_tick;

    assign last_tick = tick_i && (cnt_q == ONE);

    always_comb begin
        if (cnt_q == '0 || last_tick) st_next = ST_RUN;
        else                          st_next = ST_COUNT;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || hold_i) begin
            cnt_q <= LOAD;
            st_q  <= ST_HOLD;
        end else begin
            if (tick_i && cnt_q != '0) cnt_q <= cnt_q - ONE;
            st_q <= st_next;
        end
    end

    assign active_o = (st_q != ST_RUN);

endmodule

// File: rtl/sysrst_supervisor.sv
module sysrst_supervisor
    import sysrst_pkg::*;
#(
    parameter int unsigned STRETCH_MS  = 200,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic ms_tick_i,
    input  logic vlow_i,
    input  logic mr_n_i,
    output logic rst_n_o,
    output logic rst_o
);

    sup_in_t raw_in;
    sup_in_t sync_in;
    logic    hold;
    logic    active;

    assign raw_in = '{supply_low: vlow_i, manual_n: mr_n_i};

    sysrst_sync #(
        .WIDTH   ($bits(sup_in_t)),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SUP_IN_FAULT)
    ) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (raw_in),
        .q_o   (sync_in)
    );

    assign hold = fault_present(sync_in);

    sysrst_stretch #(
        .STRETCH (STRETCH_MS)
    ) u_stretch (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .tick_i   (ms_tick_i),
        .hold_i   (hold),
        .active_o (active)
    );

    assign rst_n_o = ~active;
    assign rst_o   = active;

endmodule

// File: rtl/sysrst_supervisor_chk.sv
module sysrst_supervisor_chk #(
    parameter int unsigned STRETCH_MS  = 200,
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic clk_i,
    input logic rst_i,
    input logic ms_tick_i,
    input logic vlow_i,
    input logic mr_n_i,
    input logic rst_n_o,
    input logic rst_o
);

    localparam int unsigned LAT = SYNC_STAGES + 1;
    localparam int unsigned QW  = $clog2(STRETCH_MS + 2) + 1;

    // Ticks seen since the last sampled fault on either input.
    logic [QW-1:0] quiet_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || vlow_i || !mr_n_i) quiet_q <= '0;
        else if (ms_tick_i && quiet_q != '1) quiet_q <= quiet_q + 1'b1;
    end

    // R7
    polarity_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rst_o != rst_n_o);

    // R2
    vlow_assert_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        vlow_i |-> ##LAT !rst_n_o);

    // R4
    manual_assert_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !mr_n_i |-> ##LAT !rst_n_o);

    // R3
    stretch_min_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(rst_n_o) |-> quiet_q >= QW'(STRETCH_MS));

    // R10
    release_on_tick_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(rst_n_o) |-> $past(ms_tick_i));

    // R1
    reset_entry_chk: assert property (@(posedge clk_i)
        rst_i |=> !rst_n_o);

endmodule

bind sysrst_supervisor sysrst_supervisor_chk #(
    .STRETCH_MS  (STRETCH_MS),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .ms_tick_i (ms_tick_i),
    .vlow_i    (vlow_i),
    .mr_n_i    (mr_n_i),
    .rst_n_o   (rst_n_o),
    .rst_o     (rst_o)
);

// File: tb/sim_sysrst_supervisor.sv
module sim_sysrst_supervisor;

    localparam int unsigned S     = 8;
    localparam int          NVEC  = 21;

    logic clk = 1'b0;
    logic rst_i;
    logic ms_tick_i;
    logic vlow_i;
    logic mr_n_i;
    logic rst_n_o;
    logic rst_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    sysrst_supervisor #(.STRETCH_MS(S), .SYNC_STAGES(2)) u0 (
        .clk_i     (clk),
        .rst_i     (rst_i),
        .ms_tick_i (ms_tick_i),
        .vlow_i    (vlow_i),
        .mr_n_i    (mr_n_i),
        .rst_n_o   (rst_n_o),
        .rst_o     (rst_o)
    );

    // {vlow, mr_n, tick, expected rst_n, cycles[7:0], requirement[3:0]}
    localparam logic [15:0] VEC [0:NVEC-1] = '{
        {1'b0, 1'b1, 1'b1, 1'b0, 8'd9,  4'd3},   // R3 still held at S+1
        {1'b0, 1'b1, 1'b1, 1'b1, 8'd1,  4'd3},   // R3 released at S+2
        {1'b0, 1'b1, 1'b1, 1'b1, 8'd5,  4'd11},  // R11 stays released
        {1'b1, 1'b1, 1'b1, 1'b1, 8'd2,  4'd2},   // R2 not before third edge
        {1'b1, 1'b1, 1'b1, 1'b0, 8'd1,  4'd2},   // R2 asserted at third edge
        {1'b1, 1'b1, 1'b1, 1'b0, 8'd20, 4'd9},   // R9 ticks while low supply
        {1'b0, 1'b1, 1'b1, 1'b0, 8'd9,  4'd3},   // R3 full stretch after fault
        {1'b0, 1'b1, 1'b1, 1'b1, 8'd1,  4'd3},   // R3
        {1'b0, 1'b0, 1'b1, 1'b0, 8'd3,  4'd4},   // R4 manual assert
        {1'b0, 1'b0, 1'b1, 1'b0, 8'd20, 4'd9},   // R9 ticks while button held
        {1'b0, 1'b1, 1'b1, 1'b0, 8'd9,  4'd5},   // R5 stretch after release
        {1'b0, 1'b1, 1'b1, 1'b1, 8'd1,  4'd5},   // R5
        {1'b0, 1'b0, 1'b0, 1'b0, 8'd3,  4'd4},   // R4 manual assert, no ticks
        {1'b0, 1'b1, 1'b0, 1'b0, 8'd50, 4'd10},  // R10 no ticks, no release
        {1'b0, 1'b1, 1'b1, 1'b0, 8'd7,  4'd10},  // R10
        {1'b0, 1'b1, 1'b1, 1'b1, 8'd1,  4'd10},  // R10 release on S-th tick
        {1'b0, 1'b0, 1'b1, 1'b0, 8'd3,  4'd6},   // R6 start a pulse
        {1'b0, 1'b1, 1'b1, 1'b0, 8'd6,  4'd6},   // R6 partly drained
        {1'b1, 1'b1, 1'b1, 1'b0, 8'd3,  4'd6},   // R6 brownout mid pulse
        {1'b0, 1'b1, 1'b1, 1'b0, 8'd9,  4'd6},   // R6 full stretch again
        {1'b0, 1'b1, 1'b1, 1'b1, 8'd1,  4'd6}    // R6
    };

    task automatic run(input logic v, input logic m, input logic t, input int n);
        vlow_i    = v;
        mr_n_i    = m;
        ms_tick_i = t;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input logic exp_n, input int req);
        checks++;
        if (rst_n_o !== exp_n || rst_o !== ~exp_n) begin
            fails++;
            $display("FAIL R%0d: rst_n_o=%b rst_o=%b expected rst_n_o=%b rst_o=%b",
                     req, rst_n_o, rst_o, exp_n, ~exp_n);
        end
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_i     = 1'b1;
        vlow_i    = 1'b0;
        mr_n_i    = 1'b1;
        ms_tick_i = 1'b0;
        @(negedge clk);
        run(1'b0, 1'b1, 1'b1, 3);
        chk(1'b0, 1);                       // R1 reset state, R7 polarity
        rst_i = 1'b0;

        for (int k = 0; k < NVEC; k++) begin
            run(VEC[k][15], VEC[k][14], VEC[k][13], int'(VEC[k][11:4]));
            chk(VEC[k][12], int'(VEC[k][3:0]));
        end

        // R1 reset in the middle of normal operation
        rst_i = 1'b1;
        run(1'b0, 1'b1, 1'b1, 2);
        chk(1'b0, 1);
        rst_i = 1'b0;
        run(1'b0, 1'b1, 1'b1, S + 1);
        chk(1'b0, 1);
        run(1'b0, 1'b1, 1'b1, 1);
        chk(1'b1, 1);

        // R8 bouncing button: single-cycle lows and highs
        run(1'b0, 1'b0, 1'b1, 3);
        chk(1'b0, 8);
        for (int b = 0; b < 5; b++) begin
            run(1'b0, 1'b1, 1'b1, 1);
            chk(1'b0, 8);
            run(1'b0, 1'b0, 1'b1, 1);
            chk(1'b0, 8);
        end
        run(1'b0, 1'b1, 1'b1, S + 1);
        chk(1'b0, 8);
        run(1'b0, 1'b1, 1'b1, 1);
        chk(1'b1, 8);

        // R7 complement after a final quiet stretch
        run(1'b0, 1'b1, 1'b1, 4);
        chk(1'b1, 7);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule